// File: doc/BRIEF.md
# Seeded Scrambled-BSSID Hash Generator

This block turns a 48-bit BSSID and a 4-bit seed into a 10-bit short identifier. The seed selects an additive pattern. The pattern is added, with carries, to each 16-bit slice of the BSSID. A CRC-16 is then run over the scrambled value, and the ten low bits of that CRC form the identifier. Because each seed gives a different identifier, two networks that collide under one seed are unlikely to collide again under another seed.

A caller pulses `start` with the BSSID and seed on the ports. The block captures them in that cycle and shifts the 48 scrambled bits through a serial CRC engine, one bit per clock. When the last bit is in, the block raises `done` for one cycle, and `hash` then carries the result. A receiver can run the block sixteen times, once per seed, to fill a lookup table.

Top module: `seeded_bssid_hash`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy` and `done` are low and `hash` is zero.
- R2: The additive pattern is the product 0x5795 × seed, keeping only the low 15 bits. The seed is 4 bits wide and unsigned.
- R3: The BSSID is treated as three 16-bit words. The first word is bits 47:32, the second is bits 31:16 and the third is bits 15:0. Bits 47:40 hold the first octet of the written address.
- R4: Each word is replaced by (word + pattern) mod 65536. This is an integer sum, not an XOR, and the carry out of bit 15 is dropped. For example, 57-89-65-58-2F-17 with pattern 0x5795 becomes AF-1E-BC-ED-86-AC.
- R5: The CRC uses generator 0x1021 and starts from 0xFFFF, with no final inversion. It takes the scrambled 48 bits most significant bit first, starting at bit 47.
- R6: `hash` equals bits 9:0 of the finished CRC.
- R7: When `start` is high and `busy` is low, the start is accepted. `busy` then goes high on the next cycle and stays high for exactly 48 cycles.
- R8: `done` is high for exactly one cycle, which is the first cycle after `busy` falls. From that cycle, `hash` holds its value until the next start is accepted.
- R9: A `start` pulse while `busy` is high is ignored. It does not change the result and does not change the busy length.
- R10: `seed` and `bssid` are sampled only in the cycle the start is accepted. Changing them while `busy` is high does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a computation; accepted only when idle |
| seed | input | 4 | Seed that selects the additive pattern |
| bssid | input | 48 | Address to hash; bits 47:40 are the first octet |
| busy | output | 1 | High while the serial CRC runs |
| done | output | 1 | One-cycle pulse when `hash` becomes valid |
| hash | output | 10 | Ten low bits of the CRC of the scrambled address |

## Verification
Every seed from 0 to 15 is applied to each of six addresses. The addresses are the worked example, all zeros, all ones, and three mixed patterns. The all-ones address makes every word addition carry out of bit 15, so any sum that keeps the carry or uses an XOR gives a different hash. Seeds of 2 and above push the raw product past 15 bits, which exposes a missing mod 2^15 reduction. Zero and mixed addresses expose errors in word order, bit order, the CRC start value or the truncation. During every run, `seed` and `bssid` are changed on each busy cycle, and some runs also pulse `start` in mid-run. These runs separate a block that captures its inputs once from one that reads them live or restarts.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  localparam int unsigned SBH_ADDR_W  = 48;
  localparam int unsigned SBH_WORD_W  = 16;
  localparam int unsigned SBH_SEED_W  = 4;
  localparam int unsigned SBH_PAT_W   = 15;
  localparam int unsigned SBH_MULT_W  = 15;
  localparam int unsigned SBH_CRC_W   = 16;
  localparam int unsigned SBH_HASH_W  = 10;
  localparam logic [SBH_MULT_W-1:0] SBH_MULT = 15'h5795;
  localparam logic [SBH_CRC_W-1:0]  SBH_POLY = 16'h1021;
  localparam logic [SBH_CRC_W-1:0]  SBH_INIT = 16'hFFFF;

  typedef enum logic {
    SBH_IDLE = 1'b0,
    SBH_RUN  = 1'b1
  } sbh_state_e;
endpackage

// File: rtl/sbh_pattern.sv
module sbh_pattern #(
  parameter int unsigned SEED_W = 4,
  parameter int unsigned MULT_W = 15,
  parameter int unsigned PAT_W  = 15,
  parameter logic [MULT_W-1:0] MULT = 15'h5795
) (
  input  logic [SEED_W-1:0] seed,
  output logic [PAT_W-1:0]  pattern
);
  localparam int unsigned PROD_W = MULT_W + SEED_W;

  logic [PROD_W-1:0] product;

  // The product is reduced modulo 2^PAT_W by keeping only the low bits.
  always_comb begin
    product = PROD_W'(MULT) * PROD_W'(seed);
    pattern = product[PAT_W-1:0];
  end
endmodule

// File: rtl/sbh_scrambler.sv
module sbh_scrambler #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAT_W  = 15
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [PAT_W-1:0]  pattern,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int unsigned NWORDS = ADDR_W / WORD_W;

  logic [WORD_W-1:0] pat_ext;
  assign pat_ext = WORD_W'(pattern);

  // Each word gets its own adder; the carry out of the top bit is dropped.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign addr_out[w*WORD_W +: WORD_W] = addr_in[w*WORD_W +: WORD_W] + pat_ext;
  end
endmodule

// File: rtl/sbh_crc_serial.sv
module sbh_crc_serial
  import sbh_pkg::*;
#(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              fin,
  output logic [CRC_W-1:0]  crc
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  sbh_state_e        state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CRC_W-1:0]  crc_q,   crc_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic              fin_q,   fin_d;
  logic              fb;
  logic              shreg_en, crc_en, cnt_en;

  always_comb begin
    state_d  = state_q;
    shreg_d  = shreg_q;
    crc_d    = crc_q;
    cnt_d    = cnt_q;
    fin_d    = 1'b0;
    shreg_en = 1'b0;
    crc_en   = 1'b0;
    cnt_en   = 1'b0;
    fb       = crc_q[CRC_W-1] ^ shreg_q[DATA_W-1];
    unique case (state_q)
      SBH_IDLE: begin
        if (load) begin
          state_d  = SBH_RUN;
          shreg_d  = data_in;
          crc_d    = INIT;
          cnt_d    = '0;
          shreg_en = 1'b1;
          crc_en   = 1'b1;
          cnt_en   = 1'b1;
        end
      end
      SBH_RUN: begin
        crc_d    = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        shreg_d  = {shreg_q[DATA_W-2:0], 1'b0};
        cnt_d    = cnt_q + 1'b1;
        shreg_en = 1'b1;
        crc_en   = 1'b1;
        cnt_en   = 1'b1;
        if (cnt_q == LAST) begin
          state_d = SBH_IDLE;
          cnt_d   = '0;
          fin_d   = 1'b1;
        end
      end
      default: state_d = SBH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SBH_IDLE;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fin_q   <= fin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (shreg_en) shreg_q <= shreg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q == SBH_RUN);
  assign fin  = fin_q;
  assign crc  = crc_q;
endmodule

// File: rtl/seeded_bssid_hash.sv
module seeded_bssid_hash
  import sbh_pkg::*;
#(
  parameter int unsigned ADDR_W = SBH_ADDR_W,
  parameter int unsigned WORD_W = SBH_WORD_W,
  parameter int unsigned SEED_W = SBH_SEED_W,
  parameter int unsigned PAT_W  = SBH_PAT_W,
  parameter int unsigned MULT_W = SBH_MULT_W,
  parameter int unsigned CRC_W  = SBH_CRC_W,
  parameter int unsigned HASH_W = SBH_HASH_W,
  parameter logic [MULT_W-1:0] MULT = SBH_MULT,
  parameter logic [CRC_W-1:0]  POLY = SBH_POLY,
  parameter logic [CRC_W-1:0]  INIT = SBH_INIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEED_W-1:0] seed,
  input  logic [ADDR_W-1:0] bssid,
  output logic              busy,
  output logic              done,
  output logic [HASH_W-1:0] hash
);
  logic [PAT_W-1:0]  pattern;
  logic [ADDR_W-1:0] scrambled;
  logic [CRC_W-1:0]  crc;

  sbh_pattern #(
    .SEED_W (SEED_W),
    .MULT_W (MULT_W),
    .PAT_W  (PAT_W),
    .MULT   (MULT)
  ) u_pattern (
    .seed    (seed),
    .pattern (pattern)
  );

  sbh_scrambler #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .PAT_W  (PAT_W)
  ) u_scrambler (
    .addr_in  (bssid),
    .pattern  (pattern),
    .addr_out (scrambled)
  );

  // The scrambled address is captured into the shift register on the accepted start.
  sbh_crc_serial #(
    .DATA_W (ADDR_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .data_in (scrambled),
    .busy    (busy),
    .fin     (done),
    .crc     (crc)
  );

  assign hash = crc[HASH_W-1:0];
endmodule

// File: rtl/sbh_checker.sv
module sbh_checker #(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned HASH_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [HASH_W-1:0] hash
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  AST_IDLE_START:    assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy); // R7
  AST_BUSY_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) (busy && run_cnt != LAST) |=> busy); // R7
  AST_BUSY_ENDS:     assert property (@(posedge clk) disable iff (!rst_n) (busy && run_cnt == LAST) |=> !busy); // R7
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AT_END:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
  AST_HASH_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(hash)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && run_cnt == LAST) |=> !busy); // R9
endmodule

bind seeded_bssid_hash sbh_checker #(
  .DATA_W (ADDR_W),
  .HASH_W (HASH_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hash  (hash)
);

// File: tb/sim_seeded_bssid_hash.sv
module sim_seeded_bssid_hash;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  seed = '0;
  logic [47:0] bssid = '0;
  logic        busy, done;
  logic [9:0]  hash;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seeded_bssid_hash u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .seed  (seed),
    .bssid (bssid),
    .busy  (busy),
    .done  (done),
    .hash  (hash)
  );

  // Expected value built from R2..R6.
  function automatic logic [9:0] expect_hash(input logic [47:0] b, input logic [3:0] s);
    logic [18:0] prod;
    logic [15:0] pat;
    logic [47:0] d;
    logic [15:0] c;
    logic        fb;
    prod = 19'h05795 * 19'(s);
    pat  = {1'b0, prod[14:0]};
    for (int w = 0; w < 3; w++) d[w*16 +: 16] = b[w*16 +: 16] + pat;
    c = 16'hFFFF;
    for (int i = 47; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c[9:0];
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [47:0] b, input logic [3:0] s, input bit poke_start);
    logic [9:0] want;
    int n;
    want = expect_hash(b, s);
    @(negedge clk);
    bssid = b;
    seed  = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      bssid = ~bssid ^ {16'h1234, 32'(n)};   // R10: inputs change while busy
      seed  = seed + 4'd5;
      start = (poke_start && n == 10);        // R9: start during busy
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 busy cycles", 48'(n), 48'd48);
    check("R8 done at busy fall", 48'(done), 48'd1);
    check("R2/R4/R5/R6/R10 hash", 48'(hash), 48'(want));
    @(negedge clk);
    check("R8 done single cycle", 48'(done), 48'd0);
    check("R8 hash held", 48'(hash), 48'(want));
    if (poke_start) check("R9 idle after ignored start", 48'(busy), 48'd0);
  endtask

  initial begin
    logic [47:0] addrs [6];
    addrs[0] = 48'h5789_6558_2F17;
    addrs[1] = 48'h0000_0000_0000;
    addrs[2] = 48'hFFFF_FFFF_FFFF;
    addrs[3] = 48'h0123_4567_89AB;
    addrs[4] = 48'hFEDC_BA98_7654;
    addrs[5] = 48'h8000_7FFF_A5A5;

    repeat (3) @(negedge clk);
    check("R1 busy in reset", 48'(busy), 48'd0);
    check("R1 done in reset", 48'(done), 48'd0);
    check("R1 hash in reset", 48'(hash), 48'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 48'(busy), 48'd0);
    check("R1 hash after reset", 48'(hash), 48'd0);

    // R4: worked example with pattern 0x5795 (seed 1); R3 word order matters here.
    run(addrs[0], 4'd1, 1'b0);

    for (int a = 0; a < 6; a++) begin
      for (int s = 0; s < 16; s++) begin
        run(addrs[a], 4'(s), (s % 3) == 0);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule